// File: doc/BRIEF.md
# Read-Sequence Write-Protect Lock

This block tracks the write-protection state of a byte-wide nonvolatile memory controller. It does not decode written command bytes at all. It watches the address of every completed read strobe and compares the stream of addresses against two fixed seven-step patterns. The two patterns share their first six addresses and differ only in the last one. One pattern clears the protection flag and the other sets it again.

The controller raises `rd_done` for one clock when a read strobe ends, with the latched address on `rd_addr`. The state of the data bus plays no part. The block keeps a step counter. Any read that breaks the expected pattern restarts the counter. When the seventh address of either pattern arrives, the matching pulse output fires combinationally in that same cycle. The flag takes its new value at the clock edge that ends the cycle, and the counter returns to idle. Write cycles of any kind, including the abort command byte FFH, are not wired to this block, so they cannot move the flag. Out of reset the memory is protected.

Top module: `seq_write_lock`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it rises, `locked` is 1 and both pulse outputs are 0.
- R2: Reads at 0x01823, 0x01820, 0x01822, 0x00418, 0x0041B, 0x00419, 0x0041A in that order raise `unlock_pulse` in the cycle of the seventh `rd_done`. `locked` is then 0 from the following edge.
- R3: The same first six addresses followed by 0x0040A raise `lock_pulse` in the cycle of the seventh `rd_done`. `locked` is then 1 from the following edge.
- R4: A read whose address is not the expected next step restarts the tracker. If that address is 0x01823, it counts as step one of a new attempt.
- R5: Only the low 16 address bits are compared with the pattern, and bits 18..16 must all be zero for a step to match. An address with any upper bit set behaves as a mismatch.
- R6: Cycles with `rd_done` low leave the tracker and the flag unchanged, so gaps between the reads of a pattern are allowed.
- R7: After a completed pattern the tracker is idle. A lone read of a tail address then fires no pulse.
- R8: A completed pattern always fires its pulse, even when the flag already holds the target value. The flag then keeps that value.
- R9: `locked` changes only at the edge that ends a cycle in which one of the two pulse outputs is high. At most one pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_done | input | 1 | One-cycle pulse marking the end of a read strobe |
| rd_addr | input | 19 | Address latched for that read |
| locked | output | 1 | 1 = writes are blocked |
| unlock_pulse | output | 1 | High in the cycle that completes the unprotect pattern |
| lock_pulse | output | 1 | High in the cycle that completes the protect pattern |

## Verification
A wrong step count is invisible until the seventh read of a pattern. It then shows either as a missing pulse or as a pulse where none belongs, and the flag is wrong one edge later. The bench therefore drives broken, restarted, gapped and repeated patterns, including ones whose out-of-place 0x01823 must count as a fresh first step. It compares both pulses and the flag against a behavioural model in every cycle, so a stale counter is reported at the first read where the two disagree.

// File: rtl/seq_write_lock.sv
module seq_write_lock #(
  parameter int AW = 19,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_done,
  input  logic [AW-1:0] rd_addr,
  output logic          locked,
  output logic          unlock_pulse,
  output logic          lock_pulse
);
  localparam int STEPS = 7;
  localparam int SW = $clog2(STEPS);
  localparam logic [CW-1:0] OPEN_TAIL  = CW'(16'h041A);
  localparam logic [CW-1:0] CLOSE_TAIL = CW'(16'h040A);

  function automatic logic [CW-1:0] step_addr(input logic [SW-1:0] idx);
    case (idx)
      3'd0:    step_addr = CW'(16'h1823);
      3'd1:    step_addr = CW'(16'h1820);
      3'd2:    step_addr = CW'(16'h1822);
      3'd3:    step_addr = CW'(16'h0418);
      3'd4:    step_addr = CW'(16'h041B);
      3'd5:    step_addr = CW'(16'h0419);
      default: step_addr = OPEN_TAIL;
    endcase
  endfunction

  logic [SW-1:0] step;
  logic          hi_zero, at_tail, hit_next, hit_first;
  logic [CW-1:0] lo;

  assign lo        = rd_addr[CW-1:0];
  assign hi_zero   = (rd_addr[AW-1:CW] == '0);
  assign at_tail   = (step == SW'(STEPS-1));
  assign hit_next  = hi_zero && !at_tail && (lo == step_addr(step));
  assign hit_first = hi_zero && (lo == step_addr('0));

  assign unlock_pulse = rd_done && at_tail && hi_zero && (lo == OPEN_TAIL);
  assign lock_pulse   = rd_done && at_tail && hi_zero && (lo == CLOSE_TAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= '0;
      locked <= 1'b1;
    end else if (rd_done) begin
      if (unlock_pulse) begin
        locked <= 1'b0;
        step   <= '0;
      end else if (lock_pulse) begin
        locked <= 1'b1;
        step   <= '0;
      end else if (hit_next) begin
        step <= step + SW'(1);
      end else begin
        step <= hit_first ? SW'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/seq_write_lock_checks.sv
module seq_write_lock_checks (
  input logic clk,
  input logic rst_n,
  input logic rd_done,
  input logic locked,
  input logic unlock_pulse,
  input logic lock_pulse
);
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unlock_pulse, lock_pulse}));
  assert_pulse_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_pulse || lock_pulse) |-> rd_done);
  assert_unlock_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |=> !locked);
  assert_lock_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse |=> locked);
  assert_flag_moves_only_on_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(unlock_pulse || lock_pulse) |=> $stable(locked));
  assert_idle_read_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> !(unlock_pulse || lock_pulse));
endmodule

bind seq_write_lock seq_write_lock_checks u_chk (.*);

// File: tb/sim_seq_write_lock.sv
`timescale 1ns/1ps
module sim_seq_write_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_done = 1'b0;
  logic [18:0] rd_addr = '0;
  logic        locked, unlock_pulse, lock_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int unsigned seq[7] = '{32'h1823, 32'h1820, 32'h1822, 32'h0418, 32'h041B, 32'h0419, 32'h041A};
  int  m_step = 0;
  bit  m_lock = 1'b1;

  always #10 clk = ~clk;

  seq_write_lock u0 (.clk(clk), .rst_n(rst_n), .rd_done(rd_done), .rd_addr(rd_addr),
                     .locked(locked), .unlock_pulse(unlock_pulse), .lock_pulse(lock_pulse));

  task automatic cycle(input bit rd, input int unsigned a, input string tag);
    bit eu, el;
    @(negedge clk);
    rd_done = rd;
    rd_addr = a[18:0];
    #5;
    eu = rst_n && rd && m_step == 6 && a == 32'h041A;
    el = rst_n && rd && m_step == 6 && a == 32'h040A;
    checks++;
    if (locked !== m_lock || unlock_pulse !== eu || lock_pulse !== el) begin
      fails++;
      $display("FAIL %s addr=%h got lk=%b up=%b lp=%b expected lk=%b up=%b lp=%b",
               tag, a, locked, unlock_pulse, lock_pulse, m_lock, eu, el);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_step = 0; m_lock = 1'b1;
    end else if (rd) begin
      if (eu) begin m_lock = 1'b0; m_step = 0; end
      else if (el) begin m_lock = 1'b1; m_step = 0; end
      else if (m_step < 6 && a == seq[m_step]) m_step++;
      else m_step = (a == 32'h1823) ? 1 : 0;
    end
  endtask

  task automatic run_seq(input int unsigned tail, input int gap, input string tag);
    for (int i = 0; i < 6; i++) begin
      cycle(1'b1, seq[i], tag);
      for (int g = 0; g < gap; g++) cycle(1'b0, 32'h7FFFF, tag);
    end
    cycle(1'b1, tail, tag);
    cycle(1'b0, 0, tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) cycle(1'b1, seq[i], "R1");
    rst_n = 1'b1;
    cycle(1'b0, 0, "R1");
    run_seq(32'h041A, 0, "R2");
    cycle(1'b1, 32'h041A, "R7");
    cycle(1'b1, 32'h040A, "R7");
    run_seq(32'h040A, 3, "R3_R6");
    run_seq(32'h040A, 0, "R8");
    foreach (seq[i]) if (i < 4) cycle(1'b1, seq[i], "R4");
    cycle(1'b1, 32'h0999, "R4");
    cycle(1'b1, 32'h041B, "R4");
    cycle(1'b1, 32'h0419, "R4");
    cycle(1'b1, 32'h041A, "R4");
    cycle(1'b1, 32'h1823, "R4");
    cycle(1'b1, 32'h1820, "R4");
    run_seq(32'h041A, 1, "R4");
    run_seq(32'h041A, 0, "R8");
    for (int i = 0; i < 6; i++) cycle(1'b1, seq[i], "R5");
    cycle(1'b1, 32'h4040A, "R5");
    cycle(1'b1, 32'h41823, "R5");
    for (int i = 1; i < 6; i++) cycle(1'b1, seq[i], "R5");
    cycle(1'b1, 32'h040A, "R5");
    for (int i = 0; i < 6; i++) cycle(1'b1, seq[i], "R9");
    cycle(1'b1, 32'h1041A, "R9");
    run_seq(32'h040A, 0, "R3");
    rst_n = 1'b0;
    cycle(1'b0, 0, "R1");
    rst_n = 1'b1;
    cycle(1'b0, 0, "R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule